// File: doc/BRIEF.md
# Serial Backup-Memory Host Controller

This block sits on the host side of a bit-serial link to an external backup memory. A local requester asks for a read or a write by giving a direction, a 16-bit byte address, a 16-bit byte count and a 10-bit option field. The controller then handles the whole exchange on the link by itself. It probes for the device with up to three attempts. It sends a 31-bit command header and moves the data bytes. After a write it checks an acknowledge bit. It always closes with three zero bits and then posts a status code.

The link runs one bit every two clocks. In the first clock the controller raises a strobe with the outgoing bit. In the second clock the device presents a 4-bit return nibble, which the controller samples at the clock edge that ends that clock. Write bytes are pulled from the requester one at a time. Read bytes are handed back one at a time together with a 16-bit running sum.

Top module: `bkp_link_ctrl`

## Requirements
- R1: Each probe attempt sends the byte 0xA8 least significant bit first, then a 0 bit, then a 1 bit. The nibble sampled after the 0 bit must be 0 and the nibble sampled after the 1 bit must be 4 for the device to count as present.
- R2: A failed probe is repeated, up to 3 attempts in total. If all attempts fail, the controller sends no header and no data. It sends three 0 bits and reports status 1.
- R3: Once the device is present, the controller sends a 31-bit header in this order: the direction bit (1 = read, 0 = write), then option bits 0 to 9, then bits 0 to 19 of a 20-bit field holding the byte address shifted left by 3.
- R4: A read moves exactly `req_count` bytes. Each byte is built least significant bit first from bit 0 of the sampled nibble, one bit per strobe, and is presented on `rd_data` with a one-cycle `rd_valid` pulse. `rd_sum` holds the 16-bit wrapping sum of the bytes read in the current transaction. A count of 0 moves no bytes.
- R5: A write moves exactly `req_count` bytes. For each byte, `wr_take` pulses for one cycle and `wr_data` is captured in that cycle. The byte is sent least significant bit first, and its first strobe comes in the cycle after the pulse.
- R6: After the write data the controller sends two 0 bits as read slots. If bit 0 of the nibble sampled in the second slot is 1, the status is 6; otherwise it is 0. A successful read reports status 0.
- R7: Every transaction ends with three 0 bits. Then `done` pulses for one cycle with `status` valid, and `busy` falls in that same cycle.
- R8: Each bit takes two clocks. `ser_stb` is high for exactly one cycle with `ser_dout` valid, and it is never high in two consecutive cycles.
- R9: `busy` rises in the cycle after a request is accepted in the idle state. While `busy` is high, `req_valid` is ignored.
- R10: After reset, `busy`, `ser_stb`, `done`, `rd_valid` and `wr_take` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_addr | input | 16 | Byte address |
| req_count | input | 16 | Number of bytes to move |
| req_opt | input | 10 | Option field placed in the header |
| wr_data | input | 8 | Write byte, captured while wr_take is high |
| wr_take | output | 1 | Write byte consumed this cycle |
| rd_valid | output | 1 | rd_data holds a new read byte |
| rd_data | output | 8 | Read byte |
| rd_sum | output | 16 | Running sum of the read bytes |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 ok, 1 no device, 6 write not acknowledged |
| ser_stb | output | 1 | Bit strobe to the link |
| ser_dout | output | 1 | Outgoing bit, valid with ser_stb |
| ser_din | input | 4 | Return nibble from the link |

## Verification
A wrong phase or bit counter shows up at the ports within one bit time: the logged outgoing bit stream gets shifted, truncated or extended against the stream the bench builds from R1, R3 and R7. A mistake in probe bookkeeping changes the number of 0xA8 bytes on the link, or the status, before the header would start. A wrong receive shift or byte count corrupts the first affected `rd_data` byte or the `wr_take` count, and `rd_sum` carries the error to the end of the transaction.

// File: rtl/bkp_link_ctrl.sv
module bkp_link_ctrl #(
  parameter int TRIES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_rd,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_count,
  input  logic [9:0]  req_opt,
  input  logic [7:0]  wr_data,
  output logic        wr_take,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic [15:0] rd_sum,
  output logic        busy,
  output logic        done,
  output logic [2:0]  status,
  output logic        ser_stb,
  output logic        ser_dout,
  input  logic [3:0]  ser_din
);
  localparam int TW = $clog2(TRIES + 1);
  localparam logic [30:0] PROBE_BITS = 31'b10_1010_1000;

  typedef enum logic [2:0] {S_IDLE, S_PROBE, S_HDR, S_LOAD, S_DATA, S_ACK, S_TAIL} st_t;

  st_t         st;
  logic        ph;
  logic [30:0] sh;
  logic [30:0] hdr_q;
  logic [4:0]  nb;
  logic [7:0]  rx;
  logic [3:0]  nib1;
  logic [TW-1:0] tries;
  logic        dir_q;
  logic [15:0] cnt;

  wire [7:0] rx_nx = {ser_din[0], rx[7:1]};

  assign busy     = (st != S_IDLE);
  assign wr_take  = (st == S_LOAD);
  assign ser_stb  = busy && (st != S_LOAD) && !ph;
  assign ser_dout = ser_stb & sh[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 1'b0; sh <= '0; hdr_q <= '0; nb <= '0; rx <= '0;
      nib1 <= '0; tries <= '0; dir_q <= 1'b0; cnt <= '0; rd_sum <= '0;
      rd_valid <= 1'b0; rd_data <= '0; done <= 1'b0; status <= '0;
    end else begin
      done <= 1'b0;
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          hdr_q  <= {1'b0, req_addr, 3'b000, req_opt, req_rd};
          dir_q  <= req_rd;
          cnt    <= req_count;
          rd_sum <= '0;
          status <= 3'd0;
          tries  <= '0;
          sh <= PROBE_BITS; nb <= 5'd10; ph <= 1'b0;
          st <= S_PROBE;
        end
        S_LOAD: begin
          sh <= {23'b0, wr_data}; nb <= 5'd8; ph <= 1'b0;
          st <= S_DATA;
        end
        default: begin
          if (!ph) ph <= 1'b1;
          else begin
            ph <= 1'b0;
            sh <= sh >> 1;
            nb <= nb - 5'd1;
            rx <= rx_nx;
            if (st == S_PROBE && nb == 5'd2) nib1 <= ser_din;
            if (nb == 5'd1) begin
              case (st)
                S_PROBE: begin
                  if (nib1 == 4'd0 && ser_din == 4'd4) begin
                    sh <= hdr_q; nb <= 5'd31; st <= S_HDR;
                  end else if (tries == TW'(TRIES - 1)) begin
                    status <= 3'd1; sh <= '0; nb <= 5'd3; st <= S_TAIL;
                  end else begin
                    tries <= tries + 1'b1;
                    sh <= PROBE_BITS; nb <= 5'd10;
                  end
                end
                S_HDR: begin
                  sh <= '0;
                  if (dir_q) begin
                    if (cnt == 16'd0) begin nb <= 5'd3; st <= S_TAIL; end
                    else begin nb <= 5'd8; st <= S_DATA; end
                  end else begin
                    if (cnt == 16'd0) begin nb <= 5'd2; st <= S_ACK; end
                    else st <= S_LOAD;
                  end
                end
                S_DATA: begin
                  cnt <= cnt - 16'd1;
                  sh <= '0;
                  if (dir_q) begin
                    rd_valid <= 1'b1;
                    rd_data  <= rx_nx;
                    rd_sum   <= rd_sum + {8'd0, rx_nx};
                  end
                  if (cnt == 16'd1) begin
                    if (dir_q) begin nb <= 5'd3; st <= S_TAIL; end
                    else begin nb <= 5'd2; st <= S_ACK; end
                  end else begin
                    if (dir_q) nb <= 5'd8;
                    else st <= S_LOAD;
                  end
                end
                S_ACK: begin
                  status <= ser_din[0] ? 3'd6 : 3'd0;
                  sh <= '0; nb <= 5'd3; st <= S_TAIL;
                end
                S_TAIL: begin
                  st <= S_IDLE;
                  done <= 1'b1;
                end
                default: st <= S_IDLE;
              endcase
            end
          end
        end
      endcase
    end
  end

  assert_stb_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ser_stb |=> !ser_stb);
  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_status_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status == 3'd0 || status == 3'd1 || status == 3'd6));
  assert_take_then_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> ser_stb);
  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);
  assert_rd_in_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy && !done);
endmodule

// File: tb/sim_bkp_link_ctrl.sv
module sim_bkp_link_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_rd = 1'b0;
  logic [15:0] req_addr = '0, req_count = '0;
  logic [9:0]  req_opt = '0;
  logic [7:0]  wr_data;
  logic [3:0]  ser_din;
  logic wr_take, rd_valid, busy, done, ser_stb, ser_dout;
  logic [7:0] rd_data;
  logic [15:0] rd_sum;
  logic [2:0] status;

  always #5 clk = ~clk;

  bkp_link_ctrl u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rd(req_rd),
    .req_addr(req_addr), .req_count(req_count), .req_opt(req_opt), .wr_data(wr_data),
    .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data), .rd_sum(rd_sum),
    .busy(busy), .done(done), .status(status), .ser_stb(ser_stb), .ser_dout(ser_dout),
    .ser_din(ser_din));

  int checks = 0, fails = 0;
  logic [7:0] rd_src [0:7];
  logic [7:0] wr_src [0:7];
  int cfg_nfail = 0, cfg_cnt = 0;
  logic cfg_rd = 1'b0, cfg_ack = 1'b0;
  int widx = 0;
  logic dlog [0:1023];
  int bidx = 0;
  logic [3:0] rsp = 4'h0;
  logic eb [0:1023];
  int en;

  assign ser_din = rsp;
  assign wr_data = wr_src[widx % 8];

  function automatic int probe_bits();
    return ((cfg_nfail >= 3) ? 3 : cfg_nfail + 1) * 10;
  endfunction

  function automatic logic [3:0] reply(input int i);
    int p, d;
    p = probe_bits();
    if (i < p) begin
      if (i % 10 == 8) return (i / 10 >= cfg_nfail) ? 4'd0 : 4'd4;
      if (i % 10 == 9) return (i / 10 >= cfg_nfail) ? 4'd4 : 4'd0;
      return 4'h2;
    end
    d = i - p - 31;
    if (cfg_rd && d >= 0 && d < 8 * cfg_cnt) return {3'b0, rd_src[d / 8][d % 8]};
    if (!cfg_rd && d == 8 * cfg_cnt) return {3'b0, ~cfg_ack};
    if (!cfg_rd && d == 8 * cfg_cnt + 1) return {3'b0, cfg_ack};
    return 4'h0;
  endfunction

  always @(posedge clk) begin
    if (!busy) begin
      bidx <= 0;
      widx <= 0;
    end else begin
      if (wr_take) widx <= widx + 1;
      if (ser_stb) begin
        if (bidx < 1024) dlog[bidx] <= ser_dout;
        rsp <= reply(bidx);
        bidx <= bidx + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic b);
    eb[en] = b; en++;
  endtask

  task automatic push_n(input logic [31:0] v, input int n);
    for (int k = 0; k < n; k++) push(v[k]);
  endtask

  task automatic run(input logic rd, input logic [15:0] addr, input logic [9:0] opt,
                     input int cnt, input int nfail, input logic ack, input bit poke);
    int p_end, h_end, d_end, nrd, ntake, bad_p, bad_h, bad_d, bad_t, got_n, t;
    logic [15:0] sum_exp;
    logic [2:0] st_exp;
    logic [7:0] got [0:7];
    logic [19:0] fld;
    cfg_rd = rd; cfg_cnt = cnt; cfg_nfail = nfail; cfg_ack = ack;
    en = 0;
    for (int a = 0; a < ((nfail >= 3) ? 3 : nfail + 1); a++) begin
      push_n(32'hA8, 8); push(1'b0); push(1'b1);
    end
    p_end = en;
    if (nfail < 3) begin
      fld = {1'b0, addr, 3'b000};
      push(rd); push_n({22'd0, opt}, 10); push_n({12'd0, fld}, 20);
    end
    h_end = en;
    if (nfail < 3) begin
      for (int b = 0; b < cnt; b++) push_n(rd ? 32'd0 : {24'd0, wr_src[b]}, 8);
      if (!rd) push_n(32'd0, 2);
    end
    d_end = en;
    push_n(32'd0, 3);
    st_exp = (nfail >= 3) ? 3'd1 : ((!rd && ack) ? 3'd6 : 3'd0);
    sum_exp = '0;
    for (int b = 0; b < cnt; b++) sum_exp += {8'd0, rd_src[b]};

    @(negedge clk);
    req_rd = rd; req_addr = addr; req_opt = opt; req_count = 16'(cnt); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
    nrd = 0; ntake = 0; got_n = 0; t = 0;
    while (!done && t < 5000) begin
      if (poke && t == 6) begin
        req_rd = ~rd; req_addr = ~addr; req_count = 16'd5; req_valid = 1'b1;
      end else req_valid = 1'b0;
      if (rd_valid) begin
        if (got_n < 8) got[got_n] = rd_data;
        got_n++;
      end
      if (wr_take) ntake++;
      @(negedge clk);
      t++;
    end
    req_valid = 1'b0;
    chk(done == 1'b1, "R7 done pulse", int'(done), 1);
    chk(busy == 1'b0, "R7 busy falls with done", int'(busy), 0);
    chk(status == st_exp, (nfail >= 3) ? "R2 status" : (rd ? "R4 status" : "R6 status"),
        int'(status), int'(st_exp));
    chk(bidx == en, poke ? "R9 bit count with ignored request" : "R8 bit count", bidx, en);
    bad_p = 0; bad_h = 0; bad_d = 0; bad_t = 0;
    for (int i = 0; i < en && i < bidx; i++) begin
      if (dlog[i] !== eb[i]) begin
        if (i < p_end) bad_p++;
        else if (i < h_end) bad_h++;
        else if (i < d_end) bad_d++;
        else bad_t++;
      end
    end
    chk(bad_p == 0, "R1 probe bits mismatched", bad_p, 0);
    chk(bad_h == 0, "R3 header bits mismatched", bad_h, 0);
    chk(bad_d == 0, "R5 data bits mismatched", bad_d, 0);
    chk(bad_t == 0, "R7 trailing zero bits mismatched", bad_t, 0);
    if (rd && nfail < 3) begin
      chk(got_n == cnt, "R4 read byte count", got_n, cnt);
      for (int b = 0; b < cnt && b < got_n; b++)
        chk(got[b] == rd_src[b], "R4 read byte", int'(got[b]), int'(rd_src[b]));
      chk(rd_sum == sum_exp, "R4 running sum", int'(rd_sum), int'(sum_exp));
    end else begin
      chk(got_n == 0, "R2 no read bytes", got_n, 0);
    end
    chk(ntake == ((!rd && nfail < 3) ? cnt : 0), "R5 wr_take count", ntake,
        (!rd && nfail < 3) ? cnt : 0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9 idle after done", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rd_src[0] = 8'h5A; rd_src[1] = 8'hC3; rd_src[2] = 8'hFF; rd_src[3] = 8'h01;
    rd_src[4] = 8'h80; rd_src[5] = 8'h7E; rd_src[6] = 8'h99; rd_src[7] = 8'h10;
    wr_src[0] = 8'hA5; wr_src[1] = 8'h3C; wr_src[2] = 8'h01; wr_src[3] = 8'hF0;
    wr_src[4] = 8'h00; wr_src[5] = 8'hFF; wr_src[6] = 8'h69; wr_src[7] = 8'h2D;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && ser_stb == 0 && done == 0 && rd_valid == 0 && wr_take == 0,
        "R10 reset state", {busy, ser_stb, done, rd_valid, wr_take}, 0);
    run(1'b1, 16'h1234, 10'h2A5, 4, 0, 1'b0, 1'b0);
    run(1'b0, 16'h00F1, 10'h001, 3, 2, 1'b0, 1'b0);
    run(1'b0, 16'hFFFF, 10'h3FF, 2, 0, 1'b1, 1'b0);
    run(1'b1, 16'h4321, 10'h155, 2, 3, 1'b0, 1'b0);
    run(1'b1, 16'h0010, 10'h200, 3, 1, 1'b0, 1'b1);
    run(1'b1, 16'h8000, 10'h000, 0, 0, 1'b0, 1'b0);
    run(1'b0, 16'h0001, 10'h0F0, 0, 0, 1'b1, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule